// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a serial EEPROM that uses a chip-select, clock, data-in and data-out pin set. A one-cycle start strobe captures a word address. The sequencer then drives the serial pins on its own and returns the fetched word together with a one-cycle completion pulse. It needs no help from software between the start and the result.

A read has four stages. The first is a flush: chip select goes high, a train of clock pulses runs while the line to the chip stays at zero, the clock returns low and chip select drops for one phase. The second stage shifts out a read command of the address width plus five bits. The third clocks in 16 data bits. The fourth repeats the flush. Every clock half-period lasts a fixed number of system clock cycles, set by a parameter, so the serial clock can be slowed to the rate the memory needs. A four-bit snapshot of the pin levels is also presented so that surrounding logic can watch the serial interface.

Top module: `uwr_word_reader`

## Requirements
- R1: While reset is held and after it is released, chip select, serial clock, data-to-chip, done and the data output are all 0. Whenever chip select is low, the serial clock and data-to-chip are also low.
- R2: The command is the value binary 00110 followed by the address bits (0x180 OR address for a 6-bit address), CMD_W = ADDR_W+5 bits long. It is sent most significant bit first, one bit per clock pulse. Each bit is set up while the clock is low and held steady while the clock is high. The command pulses are pulses number FLUSH_PULSES+1 to FLUSH_PULSES+CMD_W of a read.
- R3: The 16 pulses after the command each bring in one data bit, most significant bit first. Each bit is sampled at the end of the clock-high phase. The assembled word appears on data_o.
- R4: Before the command and again after the data, chip select stays high for FLUSH_PULSES clock pulses (26 by default). Each pulse is a low phase then a high phase. One further low phase follows, and then chip select is low for one phase. A read therefore has 2*FLUSH_PULSES+CMD_W+16 rising clock edges and two falling edges of chip select.
- R5: Every level of the serial clock lasts exactly PHASE_CYC system clock cycles. The first clock rise comes PHASE_CYC cycles after chip select goes high.
- R6: A start strobe that arrives while a read is in progress is ignored. It neither restarts the read nor causes an extra done pulse.
- R7: done_o is high for exactly one cycle per read. data_o changes only in the cycle that done_o is high, and it otherwise holds its value, including through the next read.
- R8: pins_o is {chip select, serial clock, data-from-chip, data-to-chip}, in bit positions 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle, sampled only when idle |
| addr_i | input | ADDR_W | Word address, captured with start_i |
| ee_cs_o | output | 1 | Chip select to the EEPROM |
| ee_sk_o | output | 1 | Serial clock to the EEPROM |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| pins_o | output | 4 | Pin snapshot {cs, sk, data-from-chip, data-to-chip} |
| data_o | output | DATA_W | Last word read |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the reader with PHASE_CYC = 3, ADDR_W = 6 and the default flush length of 26 pulses. With these values a whole read takes about 490 cycles, so many addresses fit in one short run, including all-zeros, all-ones and alternating patterns. A phase of three cycles rather than one means an off-by-one in the phase timer shows up as a wrong measured phase length. The full 26-pulse flush is kept, so the pulse and chip-select edge counts match the real sequence.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_FTAIL,
    ST_DESEL,
    ST_CMD,
    ST_DATA
  } uwr_state_e;
endpackage

// File: rtl/uwr_phase_timer.sv
module uwr_phase_timer #(
  parameter int PHASE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(PHASE_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uwr_shift_in.sv
module uwr_shift_in #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             sin,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= {q[WIDTH-2:0], sin};
  end
endmodule

// File: rtl/uwr_sequencer.sv
module uwr_sequencer
  import uwr_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int FLUSH_PULSES = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic [DATA_W-1:0] data_q,
  output logic              run,
  output logic              data_shift,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic              done,
  output logic [DATA_W-1:0] data_out
);
  localparam int CMD_W = ADDR_W + 5;
  localparam int MAXC  = (FLUSH_PULSES > CMD_W) ?
                         ((FLUSH_PULSES > DATA_W) ? FLUSH_PULSES : DATA_W) :
                         ((CMD_W > DATA_W) ? CMD_W : DATA_W);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] FL_LAST  = CNT_W'(FLUSH_PULSES - 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  uwr_state_e       st;
  logic             post;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_q;

  assign run        = (st != ST_IDLE);
  assign data_shift = (st == ST_DATA) && tick && sk;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      post     <= 1'b0;
      cnt      <= '0;
      cmd_q    <= '0;
      cs       <= 1'b0;
      sk       <= 1'b0;
      di       <= 1'b0;
      done     <= 1'b0;
      data_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st    <= ST_FLUSH;
            post  <= 1'b0;
            cnt   <= '0;
            cmd_q <= {2'b00, 3'b110, addr};
            cs    <= 1'b1;
            sk    <= 1'b0;
            di    <= 1'b0;
          end
        end
        ST_FLUSH: begin
          if (tick) begin
            if (!sk) sk <= 1'b1;
            else begin
              sk <= 1'b0;
              if (cnt == FL_LAST) begin
                cnt <= '0;
                st  <= ST_FTAIL;
              end else cnt <= cnt + 1'b1;
            end
          end
        end
        ST_FTAIL: begin
          if (tick) begin
            cs <= 1'b0;
            st <= ST_DESEL;
          end
        end
        ST_DESEL: begin
          if (tick) begin
            if (post) begin
              st       <= ST_IDLE;
              done     <= 1'b1;
              data_out <= data_q;
            end else begin
              cs <= 1'b1;
              di <= cmd_q[CMD_W-1];
              st <= ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (tick) begin
            if (!sk) sk <= 1'b1;
            else begin
              sk    <= 1'b0;
              cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
              if (cnt == CMD_LAST) begin
                cnt <= '0;
                di  <= 1'b0;
                st  <= ST_DATA;
              end else begin
                cnt <= cnt + 1'b1;
                di  <= cmd_q[CMD_W-2];
              end
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (!sk) sk <= 1'b1;
            else begin
              sk <= 1'b0;
              if (cnt == DAT_LAST) begin
                cnt  <= '0;
                post <= 1'b1;
                st   <= ST_FLUSH;
              end else cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwr_word_reader.sv
module uwr_word_reader #(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int FLUSH_PULSES = 26,
  parameter int PHASE_CYC    = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  output logic [3:0]        pins_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic              run;
  logic              tick;
  logic              data_shift;
  logic [DATA_W-1:0] data_q;

  uwr_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  uwr_shift_in #(.WIDTH(DATA_W)) u_capture (
    .clk   (clk),
    .rst   (rst),
    .shift (data_shift),
    .sin   (ee_do_i),
    .q     (data_q)
  );

  uwr_sequencer #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .FLUSH_PULSES (FLUSH_PULSES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .addr       (addr_i),
    .tick       (tick),
    .data_q     (data_q),
    .run        (run),
    .data_shift (data_shift),
    .cs         (ee_cs_o),
    .sk         (ee_sk_o),
    .di         (ee_di_o),
    .done       (done_o),
    .data_out   (data_o)
  );

  assign pins_o = {ee_cs_o, ee_sk_o, ee_do_i, ee_di_o};
endmodule

// File: rtl/uwr_word_reader_chk.sv
module uwr_word_reader_chk #(
  parameter int PHASE_CYC = 200,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              sk,
  input logic              di,
  input logic              done,
  input logic [DATA_W-1:0] data
);
  localparam int RW = $clog2(PHASE_CYC + 2) + 1;
  localparam logic [RW-1:0] RLAST = RW'(PHASE_CYC - 1);

  logic          prev_sk;
  logic          prev_cs;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sk <= 1'b0;
      prev_cs <= 1'b0;
      run_len <= '0;
    end else begin
      prev_sk <= sk;
      prev_cs <= cs;
      if (sk != prev_sk || cs != prev_cs) run_len <= '0;
      else if (run_len != {RW{1'b1}})     run_len <= run_len + 1'b1;
    end
  end

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (!sk && !di));

  // R2
  di_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di));

  // R5
  phase_len_chk: assert property (@(posedge clk) disable iff (rst)
    (sk != prev_sk) |-> (run_len == RLAST));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data) |-> done);
endmodule

bind uwr_word_reader uwr_word_reader_chk #(
  .PHASE_CYC (PHASE_CYC),
  .DATA_W    (DATA_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .cs   (ee_cs_o),
  .sk   (ee_sk_o),
  .di   (ee_di_o),
  .done (done_o),
  .data (data_o)
);

// File: tb/uwr_word_reader_bench.sv
module uwr_word_reader_bench;
  localparam int P   = 3;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int FP  = 26;
  localparam int CW  = AW + 5;
  localparam int ALL_RISES = 2*FP + CW + DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs, sk, di, do_i;
  logic [3:0]    pins;
  logic [DW-1:0] data;
  logic          done;

  int checks = 0;
  int errors = 0;
  int exp_dones = 0;
  int got_dones = 0;
  logic [AW+DW-1:0] q[$];

  always #5 clk = ~clk;

  uwr_word_reader #(
    .ADDR_W(AW), .DATA_W(DW), .FLUSH_PULSES(FP), .PHASE_CYC(P)
  ) u_uwr_word_reader (
    .clk(clk), .rst(rst), .start_i(start), .addr_i(addr),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(do_i),
    .pins_o(pins), .data_o(data), .done_o(done)
  );

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    return {a, ~a[3:0], a} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model: ignores zeros until a start bit, then opcode+address, then data
  int            m_st = 0;
  int            m_cnt = 0;
  int            m_idx = 0;
  logic [AW+1:0] m_sh = '0;
  logic [AW-1:0] m_addr = '0;
  logic          m_do = 1'b0;
  logic          m_last_sk = 1'b0;
  assign do_i = m_do;

  always @(negedge clk) begin
    if (!cs) begin
      m_st = 0; m_cnt = 0; m_idx = 0; m_do = 1'b0;
    end else if (sk && !m_last_sk) begin
      case (m_st)
        0: if (di) begin m_st = 1; m_cnt = 0; end
        1: begin
          m_sh = {m_sh[AW:0], di};
          m_cnt++;
          if (m_cnt == AW + 2) begin
            m_addr = m_sh[AW-1:0];
            m_idx = 0;
            m_st = 2;
          end
        end
        default: begin
          if (m_idx < DW) begin
            m_do = rom_word(m_addr)[DW-1-m_idx];
            m_idx++;
          end else m_do = 1'b0;
        end
      endcase
    end
    m_last_sk = sk;
  end

  // Monitor / scoreboard
  bit            in_txn = 0;
  int            rises = 0, cs_falls = 0, since = 0;
  bit            bad_phase = 0, di_bad = 0;
  logic [CW-1:0] cmd_cap = '0;
  logic          mon_sk = 0, mon_cs = 0, mon_di = 0, last_done = 0;

  always @(negedge clk) begin
    if (rst) begin
      in_txn = 0;
    end else begin
      if (last_done) chk(!done, "R7 done one cycle", done, 0);
      if (cs && !mon_cs && !in_txn) begin
        in_txn = 1; rises = 0; cs_falls = 0; cmd_cap = '0;
        bad_phase = 0; di_bad = 0; since = 1;
      end else if (sk != mon_sk) begin
        if (in_txn && since != P) bad_phase = 1;
        since = 1;
      end else if (cs != mon_cs) since = 1;
      else since++;
      if (sk && !mon_sk && cs) begin
        rises++;
        if (rises > FP && rises <= FP + CW) cmd_cap = {cmd_cap[CW-2:0], di};
      end
      if (sk && mon_sk && di != mon_di) di_bad = 1;
      if (!cs && mon_cs) cs_falls++;
      if (done) begin
        logic [AW+DW-1:0] e;
        got_dones++;
        in_txn = 0;
        if (q.size() == 0) chk(0, "R6 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(data == e[DW-1:0], "R3 data word", data, e[DW-1:0]);
          chk(cmd_cap == CW'(11'h180 | e[AW+DW-1:DW]), "R2 command bits", cmd_cap, 11'h180 | e[AW+DW-1:DW]);
          chk(!di_bad, "R2 data-to-chip steady while clock high", di_bad, 0);
          chk(rises == ALL_RISES, "R4 clock pulse count", rises, ALL_RISES);
          chk(cs_falls == 2, "R4 chip select drops", cs_falls, 2);
          chk(!bad_phase, "R5 phase length", bad_phase, 0);
        end
      end
    end
    mon_sk = sk; mon_cs = cs; mon_di = di; last_done = done;
  end

  task automatic issue_read(input logic [AW-1:0] a);
    @(negedge clk);
    start = 1'b1; addr = a;
    q.push_back({a, rom_word(a)});
    exp_dones++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs, sk, di, done} == 4'b0, "R1 pins in reset", {cs, sk, di, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({cs, sk, di, done} == 4'b0 && data == '0, "R1 pins after reset", {cs, sk, di, done}, 0);

    issue_read(6'h00); wait_done();
    issue_read(6'h3F); wait_done();
    issue_read(6'h2A); wait_done();
    issue_read(6'h15);
    repeat (100) @(negedge clk);
    // R8 pin snapshot mid-read
    chk(pins == {cs, sk, do_i, di} && cs, "R8 pin snapshot", pins, {cs, sk, do_i, di});
    wait_done();

    // R7 hold across idle and next read
    held = data;
    repeat (50) @(negedge clk);
    chk(data == held, "R7 hold while idle", data, held);
    issue_read(6'h01);
    repeat (150) @(negedge clk);
    chk(data == held, "R7 hold during next read", data, held);
    wait_done();

    // R6 start while busy ignored
    issue_read(6'h05);
    repeat (40) @(negedge clk);
    start = 1'b1; addr = 6'h09;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (600) @(negedge clk);
    chk(got_dones == exp_dones, "R6 done count", got_dones, exp_dones);
    chk(q.size() == 0, "R6 queue drained", q.size(), 0);

    // R1 reset mid-read
    issue_read(6'h07);
    repeat (200) @(negedge clk);
    rst = 1'b1;
    q.delete();
    exp_dones--;
    @(negedge clk);
    @(negedge clk);
    chk({cs, sk, di, done} == 4'b0, "R1 pins after mid-read reset", {cs, sk, di, done}, 0);
    rst = 1'b0;
    issue_read(6'h08); wait_done();
    chk(got_dones == exp_dones, "R6 total done count", got_dones, exp_dones);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule